// File: doc/BRIEF.md
# Interleaved Burst Read Data Sequencer

This block drives the cache data SRAM during a four-doubleword burst read that hits in the cache. When a burst begins with a hit, it captures the requested doubleword index and the bank configuration. It then steps through the line in the processor's burst order, driving a chip enable, an output enable and the low doubleword address bits for each bank. It raises a ready strobe once for every doubleword placed on the bus.

With two 32-bit banks, address bit 2 picks the bank. The access to the next bank starts while the previous bank is still driving the bus, which gives 2-1-1-1 timing. With one bank every doubleword is an access cycle followed by a transfer cycle, which gives 2-2-2-2 timing. A burst that starts on a miss is not sequenced. The block only answers it with a one-cycle acknowledge so that the fill logic can take over.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is held and after it is released, every output is low: no bank enable, no output enable, all bank address bits zero, no ready, no last, not busy, no miss acknowledge.
- R2: For a captured starting index s, the k-th ready (k = 0..3) carries doubleword s XOR k on the address bits of the bank whose output enable is high. Bank b's address bits are `bank_dw[2b+1:2b]`. Bits of a bank whose enable is low read zero.
- R3: In two-bank mode, with the start cycle counted as cycle 0, ready is high in cycles 2, 3, 4 and 5 and low in cycle 1.
- R4: In one-bank mode, ready is high in cycles 2, 4, 6 and 8 and low in between. Bank 1 (`bank_ce[1]`) is never enabled.
- R5: In two-bank mode, a doubleword with index d is read from bank d[0] (address bit 2), so successive transfers alternate banks.
- R6: In two-bank mode, each bank is enabled with its doubleword address one cycle before its transfer, with output enable low. During each of the first three transfers, both bank enables are high.
- R7: Exactly one output enable is high in each ready cycle and none otherwise. An output enable is never high without its bank enable.
- R8: `xfer_last` is high only together with the fourth ready of a burst.
- R9: A start with hit low causes no SRAM activity and no ready, and `miss_ack` pulses high for the single cycle after the start.
- R10: `busy` is high from cycle 1 through the cycle of the last transfer. A start (hit or miss) in any cycle where `busy` is high is ignored.
- R11: The start index and the bank mode are captured only at an accepted start. Changing `start_dw` or `two_bank` during a burst has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| burst_start | input | 1 | One-cycle request to begin a burst read |
| start_dw | input | 2 | Requested doubleword index within the line (address bits 3:2) |
| two_bank | input | 1 | 1 = two interleaved banks, 0 = single bank |
| hit | input | 1 | Tag lookup result for the request, sampled with burst_start |
| bank_ce | output | 2 | Per-bank SRAM chip enable, active high |
| bank_oe | output | 2 | Per-bank SRAM output enable, active high |
| bank_dw | output | 4 | Per-bank doubleword address, 2 bits per bank, bank 0 in the low bits |
| xfer_rdy | output | 1 | Valid doubleword on the bus this cycle |
| xfer_last | output | 1 | Marks the fourth doubleword |
| busy | output | 1 | A burst is being sequenced |
| miss_ack | output | 1 | One-cycle answer to a start that missed |

## Verification
The bound checker watches the structural rules on every cycle. These are the single output enable per ready, enable-before-output, last only with ready, the back-to-back spacing in two-bank mode, the enforced gap and unused second bank in one-bank mode, the overlap of both enables, and a quiet bus around a miss acknowledge. Some properties depend on the whole stimulus history, and only the bench's scenarios show them: the exact burst order for each of the four starting indices, the cycle in which the first ready lands, the rejection of starts during a burst including one on its final cycle, and immunity to mid-burst changes of the address and mode inputs. The bench checks these with a behavioural reference model compared on every clock.

// File: rtl/bseq_pkg.sv
// Package: shared constants and types for the burst read sequencer.
// Assumes a power-of-two beat count so that XOR ordering covers the line.
package bseq_pkg;
    localparam int unsigned LINE_BEATS = 4;
    localparam int unsigned NBANK      = 2;
    localparam int unsigned IDX_W      = $clog2(LINE_BEATS);
    localparam int unsigned STEP_W     = $clog2(2 * LINE_BEATS);

    typedef logic [IDX_W-1:0] dw_idx_t;

    // One pending bank operation: which doubleword, and whether it exists.
    typedef struct packed {
        logic    valid;
        dw_idx_t dw;
    } slot_t;
endpackage

// File: rtl/bseq_ctrl.sv
// Module: bseq_ctrl
// Holds the burst state: an active flag, a step counter that counts the
// cycles since acceptance, and the start index and bank mode captured when
// a hit burst is accepted. Starts are ignored while active. A miss start
// produces a one-cycle acknowledge.
// Assumes burst_start and hit are valid together in the same cycle.
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_start,
    input  dw_idx_t           start_dw,
    input  logic              two_bank,
    input  logic              hit,
    output logic              active,
    output logic [STEP_W-1:0] step,
    output dw_idx_t           start_q,
    output logic              two_q,
    output logic              miss_ack
);
    logic [STEP_W-1:0] last_step;

    // Final step index: overlapped mode ends one cycle after its last access.
    always_comb begin
        last_step = two_q ? STEP_W'(LINE_BEATS) : STEP_W'(2 * LINE_BEATS - 1);
    end

    // Accept, advance and retire bursts; flag misses seen while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            step     <= '0;
            start_q  <= '0;
            two_q    <= 1'b0;
            miss_ack <= 1'b0;
        end else begin
            miss_ack <= burst_start && !active && !hit;
            if (!active) begin
                if (burst_start && hit) begin
                    active  <= 1'b1;
                    step    <= '0;
                    start_q <= start_dw;
                    two_q   <= two_bank;
                end
            end else if (step == last_step) begin
                active <= 1'b0;
                step   <= '0;
            end else begin
                step <= step + STEP_W'(1);
            end
        end
    end
endmodule

// File: rtl/bseq_slots.sv
// Module: bseq_slots
// Decodes the step counter into the two operations of the current cycle:
// the access slot (a bank is addressed and its data is not yet driven) and
// the transfer slot (a bank drives the bus and ready is raised). In
// overlapped mode both slots can be valid at once. In single-bank mode
// they alternate. Doubleword order is start XOR beat.
module bseq_slots
    import bseq_pkg::*;
(
    input  logic              active,
    input  logic              two_q,
    input  dw_idx_t           start_q,
    input  logic [STEP_W-1:0] step,
    output slot_t             acc,
    output slot_t             xfr,
    output logic              xfr_last
);
    logic [STEP_W-1:0] step_m1;
    dw_idx_t           half_beat;

    // Previous step and the beat number for the single-bank pairing.
    always_comb begin
        step_m1   = step - STEP_W'(1);
        half_beat = step[IDX_W:1];
    end

    // Map the step to access and transfer operations for the active mode.
    always_comb begin
        acc      = '0;
        xfr      = '0;
        xfr_last = 1'b0;
        if (active) begin
            if (two_q) begin
                if (step < STEP_W'(LINE_BEATS)) begin
                    acc.valid = 1'b1;
                    acc.dw    = start_q ^ step[IDX_W-1:0];
                end
                if (step != '0) begin
                    xfr.valid = 1'b1;
                    xfr.dw    = start_q ^ step_m1[IDX_W-1:0];
                    xfr_last  = (step == STEP_W'(LINE_BEATS));
                end
            end else begin
                if (!step[0]) begin
                    acc.valid = 1'b1;
                    acc.dw    = start_q ^ half_beat;
                end else begin
                    xfr.valid = 1'b1;
                    xfr.dw    = start_q ^ half_beat;
                    xfr_last  = (half_beat == dw_idx_t'(LINE_BEATS - 1));
                end
            end
        end
    end
endmodule

// File: rtl/bseq_bank_drv.sv
// Module: bseq_bank_drv
// Drives one SRAM bank. In overlapped mode the bank owns the doublewords
// whose index bit 0 (address bit 2) equals its number. In single-bank mode
// only bank 0 is used. Address bits read zero when the bank is not enabled.
// Assumes the access and transfer slots never target the same bank at once.
module bseq_bank_drv
    import bseq_pkg::*;
#(
    parameter int unsigned BANK_ID = 0
) (
    input  logic    two_q,
    input  slot_t   acc,
    input  slot_t   xfr,
    output logic    ce,
    output logic    oe,
    output dw_idx_t dw
);
    localparam logic SEL_BIT    = BANK_ID[0];
    localparam logic IS_PRIMARY = (BANK_ID == 0);

    logic own_acc;
    logic own_xfr;

    // Decide whether each slot belongs to this bank.
    always_comb begin
        own_acc = acc.valid && (two_q ? (acc.dw[0] == SEL_BIT) : IS_PRIMARY);
        own_xfr = xfr.valid && (two_q ? (xfr.dw[0] == SEL_BIT) : IS_PRIMARY);
    end

    // Produce the bank's enables and address from the owned slot.
    always_comb begin
        ce = own_acc || own_xfr;
        oe = own_xfr;
        if (own_xfr)      dw = xfr.dw;
        else if (own_acc) dw = acc.dw;
        else              dw = '0;
    end
endmodule

// File: rtl/burst_read_seq.sv
// Module: burst_read_seq (top)
// Sequences the data SRAM banks through one burst read hit. The control
// block captures the request, the slot decoder turns the step into access
// and transfer operations, and one driver per bank produces the enables
// and address bits. Ready and last come from the transfer slot.
// Assumes tag lookup has produced hit in the same cycle as burst_start.
module burst_read_seq
    import bseq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   burst_start,
    input  logic [IDX_W-1:0]       start_dw,
    input  logic                   two_bank,
    input  logic                   hit,
    output logic [NBANK-1:0]       bank_ce,
    output logic [NBANK-1:0]       bank_oe,
    output logic [NBANK*IDX_W-1:0] bank_dw,
    output logic                   xfer_rdy,
    output logic                   xfer_last,
    output logic                   busy,
    output logic                   miss_ack
);
    logic              active;
    logic [STEP_W-1:0] step;
    dw_idx_t           start_q;
    logic              two_q;
    slot_t             acc;
    slot_t             xfr;
    logic              xfr_last;

    bseq_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .burst_start (burst_start),
        .start_dw    (start_dw),
        .two_bank    (two_bank),
        .hit         (hit),
        .active      (active),
        .step        (step),
        .start_q     (start_q),
        .two_q       (two_q),
        .miss_ack    (miss_ack)
    );

    bseq_slots u_slots (
        .active   (active),
        .two_q    (two_q),
        .start_q  (start_q),
        .step     (step),
        .acc      (acc),
        .xfr      (xfr),
        .xfr_last (xfr_last)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bseq_bank_drv #(.BANK_ID(b)) u_drv (
            .two_q (two_q),
            .acc   (acc),
            .xfr   (xfr),
            .ce    (bank_ce[b]),
            .oe    (bank_oe[b]),
            .dw    (bank_dw[b*IDX_W +: IDX_W])
        );
    end

    // Bus-side strobes follow the transfer slot.
    always_comb begin
        xfer_rdy  = xfr.valid;
        xfer_last = xfr_last;
        busy      = active;
    end
endmodule

// File: rtl/bseq_checker.sv
// Module: bseq_checker
// Cycle-by-cycle protocol properties of the sequencer, bound to the top.
// Uses the captured bank mode to pick the timing rule that applies.
module bseq_checker
    import bseq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NBANK-1:0] bank_ce,
    input logic [NBANK-1:0] bank_oe,
    input logic             xfer_rdy,
    input logic             xfer_last,
    input logic             busy,
    input logic             miss_ack,
    input logic             mode_two
);
    assert_oe_within_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_oe & ~bank_ce) == '0);

    assert_one_oe_per_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_rdy |-> $countones(bank_oe) == 1);

    assert_no_oe_without_rdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_rdy |-> bank_oe == '0);

    assert_last_with_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_last |-> (xfer_rdy && busy));

    assert_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_rdy && mode_two && !xfer_last) |=> xfer_rdy);

    assert_overlap_both_ce_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_rdy && mode_two && !xfer_last) |-> bank_ce == '1);

    assert_single_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_rdy && !mode_two) |=> !xfer_rdy);

    assert_single_bank0_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mode_two) |-> !bank_ce[1]);

    assert_retire_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_last |=> !busy);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bank_ce == '0 && !xfer_rdy));

    assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ack |-> (!busy && bank_ce == '0));
endmodule

bind burst_read_seq bseq_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bank_ce   (bank_ce),
    .bank_oe   (bank_oe),
    .xfer_rdy  (xfer_rdy),
    .xfer_last (xfer_last),
    .busy      (busy),
    .miss_ack  (miss_ack),
    .mode_two  (two_q)
);

// File: tb/burst_read_seq_bench.sv
module burst_read_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_start = 1'b0;
    logic [1:0] start_dw = 2'd0;
    logic       two_bank = 1'b0;
    logic       hit = 1'b0;
    logic [1:0] bank_ce;
    logic [1:0] bank_oe;
    logic [3:0] bank_dw;
    logic       xfer_rdy;
    logic       xfer_last;
    logic       busy;
    logic       miss_ack;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 1'b0;
    string scen = "reset";
    bit cur_busy = 1'b0;

    // Expected vector: {busy, miss, rdy, last, ce[1:0], oe[1:0], dw[3:0]}
    logic [13:0] expq[$];

    always #10 clk = ~clk;

    burst_read_seq u_burst_read_seq (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .start_dw(start_dw),
        .two_bank(two_bank), .hit(hit), .bank_ce(bank_ce), .bank_oe(bank_oe),
        .bank_dw(bank_dw), .xfer_rdy(xfer_rdy), .xfer_last(xfer_last),
        .busy(busy), .miss_ack(miss_ack)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s [%s] t=%0t actual=%0h expected=%0h", req, scen, $time, act, exp);
        end
    endtask

    // Build the expected cycle-by-cycle schedule of an accepted hit burst.
    task automatic plan_hit(input int s, input bit two);
        int n;
        n = two ? 5 : 8;
        for (int t = 0; t < n; t++) begin
            logic [13:0] v;
            int d;
            int b;
            v = '0;
            v[13] = 1'b1;
            if (two) begin
                if (t < 4) begin
                    d = s ^ t; b = d & 1;
                    v[8 + b] = 1'b1;
                    v[2*b +: 2] = 2'(d);
                end
                if (t >= 1) begin
                    d = s ^ (t - 1); b = d & 1;
                    v[8 + b] = 1'b1; v[6 + b] = 1'b1;
                    v[2*b +: 2] = 2'(d);
                    v[11] = 1'b1; v[10] = (t - 1 == 3);
                end
            end else begin
                d = s ^ (t / 2);
                v[8] = 1'b1; v[1:0] = 2'(d);
                if (t % 2 == 1) begin
                    v[6] = 1'b1; v[11] = 1'b1; v[10] = (t / 2 == 3);
                end
            end
            expq.push_back(v);
        end
    endtask

    // Compare this cycle's outputs with the model, then drive the next inputs.
    task automatic step(input bit st, input int a, input bit tb, input bit h);
        logic [13:0] e;
        @(negedge clk);
        e = (expq.size() > 0) ? expq.pop_front() : 14'd0;
        cur_busy = e[13];
        chk("R10", busy, e[13]);
        chk("R9", miss_ack, e[12]);
        chk(two_bank_mode_tag(), xfer_rdy, e[11]);
        chk("R8", xfer_last, e[10]);
        chk("R7", bank_oe, e[7:6]);
        chk("R2", bank_dw, e[3:0]);
        if (e[9:8] == 2'b11) chk("R6", bank_ce, 2'b11);
        else chk("R5", bank_ce, e[9:8]);
        burst_start = st; start_dw = 2'(a); two_bank = tb; hit = h;
        if (st && !cur_busy) begin
            if (h) plan_hit(a, tb);
            else expq.push_back(14'b01_0000_0000_0000);
        end
    endtask

    string mode_tag = "R3";
    function automatic string two_bank_mode_tag();
        return mode_tag;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, two_bank, 1'b0);
    endtask

    initial begin
        // R1: outputs idle during and after reset
        repeat (3) @(negedge clk);
        scen = "R1 reset";
        chk("R1", {busy, miss_ack, xfer_rdy, xfer_last, bank_ce, bank_oe, bank_dw}, 0);
        rst_n = 1'b1;
        idle(2);

        // R3 R5 R6 R2: two-bank bursts from every starting index
        mode_tag = "R3";
        for (int s = 0; s < 4; s++) begin
            scen = $sformatf("R3 two-bank start=%0d", s);
            step(1'b1, s, 1'b1, 1'b1);
            idle(7);
        end

        // R4 R2: single-bank bursts from every starting index
        mode_tag = "R4";
        for (int s = 0; s < 4; s++) begin
            scen = $sformatf("R4 one-bank start=%0d", s);
            step(1'b1, s, 1'b0, 1'b1);
            idle(10);
        end

        // R9: miss start
        scen = "R9 miss";
        step(1'b1, 2, 1'b1, 1'b0);
        idle(4);

        // R10: starts during a burst, including on its final cycle
        mode_tag = "R3";
        scen = "R10 start while busy";
        step(1'b1, 1, 1'b1, 1'b1);
        step(1'b1, 3, 1'b1, 1'b1);
        step(1'b1, 2, 1'b1, 1'b0);
        idle(2);
        step(1'b1, 0, 1'b1, 1'b1);
        step(1'b1, 2, 1'b1, 1'b1);
        idle(7);

        // R11: mode and index change mid-burst
        mode_tag = "R4";
        scen = "R11 mid-burst input change";
        step(1'b1, 3, 1'b0, 1'b1);
        for (int i = 0; i < 8; i++) step(1'b0, i, i[0], 1'b1);
        idle(3);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule